// File: doc/BRIEF.md
# Watchdog Timer with Locked Configuration

The block counts pulses of a slow tick enable and acts when the count reaches a programmable limit. Depending on which of its two enables are set it raises an interrupt, emits a one-cycle system reset pulse, or does both in sequence: interrupt on the first expiry and reset on a later one. Firmware restarts the count with a kick strobe before it expires.

Configuration arrives as single-byte writes. The interrupt enable can be changed freely. Turning the reset enable on is also free. Turning it off, or changing the timeout select, only takes effect inside a short window that an unlock write opens. A strap input forces reset mode on permanently. Acknowledging the interrupt while both enables are set clears the interrupt enable, so the next expiry resets the system unless firmware re-arms the interrupt.

Write byte layout: bit 0 is the interrupt enable (`ien`), bit 1 is the reset enable (`ren`), bit 2 is the unlock flag, bit 3 is unused, and bits 7:4 are the timeout select.

Top module: `wdog_locked`

## Requirements
- R1: After reset `irq` and `rst_pulse` are 0, both enables are off, and the select is 0. With both enables off and the strap low, ticks produce neither output.
- R2: When only `ien` is set, an expiry sets `irq` and restarts the count without pulsing `rst_pulse`. The flag stays set until it is acknowledged.
- R3: When reset mode is active and `ien` is clear, every expiry drives `rst_pulse` high for exactly one cycle, and the count restarts.
- R4: With both enables set, the first expiry sets `irq` only. An acknowledge then clears `irq` and `ien`, and the next expiry pulses `rst_pulse`. An expiry while `irq` is still pending also pulses `rst_pulse`.
- R5: A `kick` clears the count. The next expiry needs the full tick count measured from the kick.
- R6: A select code k from 0 to 9 gives an expiry after 2^(BASE_LOG2+k) ticks. Codes 10 to 15 behave like code 0.
- R7: A write with bit 2 and bit 1 both set is an unlock. It opens a window of WIN_CYC (4) cycles. A write landing on any of the next four clock edges updates `ren` and the select, and it closes the window.
- R8: Outside the window, a write leaves the select unchanged and cannot clear `ren`.
- R9: Writing bit 1 as 1 turns reset mode on at any time without an unlock.
- R10: While `strap_on` is high, reset mode is active whatever the register state, and no write sequence turns it off.
- R11: `irq_ack` clears `irq`. In interrupt-only mode `ien` stays set, so the next expiry raises `irq` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_data | input | 8 | Write byte: [0] ien, [1] ren, [2] unlock, [7:4] select |
| kick | input | 1 | Restarts the count |
| tick | input | 1 | Slow time-base enable, one count per cycle high |
| strap_on | input | 1 | Forces reset mode on |
| irq_ack | input | 1 | Interrupt acknowledge |
| irq | output | 1 | Pending watchdog interrupt |
| rst_pulse | output | 1 | One-cycle system reset request |

## Verification
Directed sequences place the config write at the fourth and the fifth edge after an unlock. They also attempt the same write without an unlock. Together these separate an accepted change from an ignored one by the expiry length that follows. Each mode is driven through expiry, both with an acknowledge and with the interrupt left pending, and the strap is tried against an unlock-and-clear sequence. Random select codes, including reserved ones, are combined with irregular tick gaps. The bench counts only the cycles in which a tick is active, so the measured expiry must match the computed limit whatever the spacing of the ticks.

// File: rtl/wdog_locked.sv
module wdog_locked #(
  parameter int BASE_LOG2 = 11,
  parameter int NUM_SEL   = 10,
  parameter int SEL_W     = 4,
  parameter int WIN_CYC   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       kick,
  input  logic       tick,
  input  logic       strap_on,
  input  logic       irq_ack,
  output logic       irq,
  output logic       rst_pulse
);
  localparam int CNT_W = BASE_LOG2 + NUM_SEL;
  localparam int WIN_W = $clog2(WIN_CYC + 1);

  logic             ien_q, ren_q, flag_q, pulse_q;
  logic [SEL_W-1:0] sel_q, sel_eff;
  logic [WIN_W-1:0] win_cnt;
  logic [CNT_W-1:0] cnt, lim_m1;
  logic             rst_mode, active, unlock_wr, win_open, cfg_wr, expire;

  assign rst_mode  = ren_q | strap_on;
  assign active    = ien_q | rst_mode;
  assign unlock_wr = wr_en & wr_data[2] & wr_data[1];
  assign win_open  = win_cnt != '0;
  assign cfg_wr    = wr_en & ~unlock_wr & win_open;
  assign sel_eff   = (int'(sel_q) < NUM_SEL) ? sel_q : '0;
  assign lim_m1    = ({{(CNT_W-1){1'b0}}, 1'b1} << (BASE_LOG2 + int'(sel_eff))) - 1'b1;
  assign expire    = active & tick & ~kick & (cnt >= lim_m1);
  assign irq       = flag_q;
  assign rst_pulse = pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q   <= 1'b0;
      ren_q   <= 1'b0;
      flag_q  <= 1'b0;
      pulse_q <= 1'b0;
      sel_q   <= '0;
      win_cnt <= '0;
      cnt     <= '0;
    end else begin
      pulse_q <= 1'b0;

      if (unlock_wr)     win_cnt <= WIN_W'(WIN_CYC);
      else if (cfg_wr)   win_cnt <= '0;
      else if (win_open) win_cnt <= win_cnt - 1'b1;

      if (wr_en) ien_q <= wr_data[0];
      if (wr_en && wr_data[1]) ren_q <= 1'b1;
      else if (cfg_wr)         ren_q <= 1'b0;
      if (cfg_wr) sel_q <= wr_data[7:4];

      if (!active || kick)    cnt <= '0;
      else if (tick)          cnt <= (cnt >= lim_m1) ? '0 : cnt + 1'b1;

      if (irq_ack) begin
        flag_q <= 1'b0;
        if (rst_mode) ien_q <= 1'b0;
      end

      if (expire) begin
        if (ien_q && !(rst_mode && flag_q)) flag_q  <= 1'b1;
        else if (rst_mode)                  pulse_q <= 1'b1;
      end
    end
  end
endmodule

module wdog_locked_chk #(
  parameter int SEL_W = 4,
  parameter int WIN_W = 3,
  parameter int CNT_W = 21
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             kick,
  input logic             irq_ack,
  input logic             irq,
  input logic             rst_pulse,
  input logic             ien_q,
  input logic             rst_mode,
  input logic             unlock_wr,
  input logic [SEL_W-1:0] sel_q,
  input logic [WIN_W-1:0] win_cnt,
  input logic [CNT_W-1:0] cnt
);
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |=> !rst_pulse);
  a_r3_pulse_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_pulse) |-> $past(rst_mode));
  a_r2_irq_needs_ien: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(ien_q) && !rst_pulse));
  a_r4_ack_drops_ien: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && rst_mode && !wr_en) |=> (!ien_q && !irq));
  a_r5_kick_clears: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (cnt == '0));
  a_r8_sel_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q != $past(sel_q)) |-> $past(wr_en && !unlock_wr && win_cnt != '0));
  a_r7_window_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
    ((win_cnt != '0) && !wr_en) |=> (win_cnt == $past(win_cnt) - 1'b1));
endmodule

bind wdog_locked wdog_locked_chk #(
  .SEL_W(SEL_W), .WIN_W(WIN_W), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .kick(kick), .irq_ack(irq_ack),
  .irq(irq), .rst_pulse(rst_pulse), .ien_q(ien_q), .rst_mode(rst_mode),
  .unlock_wr(unlock_wr), .sel_q(sel_q), .win_cnt(win_cnt), .cnt(cnt)
);

// File: tb/wdog_locked_tb.sv
module wdog_locked_tb_top;
  localparam int BASE = 2;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, kick = 1'b0, tick = 1'b0, strap_on = 1'b0, irq_ack = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic irq, rst_pulse;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wdog_locked #(.BASE_LOG2(BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .kick(kick),
    .tick(tick), .strap_on(strap_on), .irq_ack(irq_ack), .irq(irq), .rst_pulse(rst_pulse));

  function automatic int lim(int code);
    return (1 << BASE) << ((code < 10) ? code : 0);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(); @(posedge clk); #1; endtask
  task automatic wr(logic [7:0] d); wr_en = 1'b1; wr_data = d; cyc(); wr_en = 1'b0; endtask
  task automatic kk(); kick = 1'b1; cyc(); kick = 1'b0; endtask
  task automatic ack(); irq_ack = 1'b1; cyc(); irq_ack = 1'b0; endtask
  task automatic ticks(int n); tick = 1'b1; repeat (n) cyc(); tick = 1'b0; endtask

  task automatic exp_pulse(int n, string tag);
    ticks(n - 1); chk(!rst_pulse, tag, rst_pulse, 0);
    ticks(1);     chk(rst_pulse, tag, rst_pulse, 1);
    cyc();        chk(!rst_pulse, tag, rst_pulse, 0);
  endtask

  task automatic exp_irq(int n, string tag);
    ticks(n - 1); chk(!irq, tag, irq, 0);
    ticks(1);     chk(irq && !rst_pulse, tag, {irq, rst_pulse}, 2);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) cyc();
    rst_n = 1'b1; cyc();
    chk(!irq && !rst_pulse, "R1 reset", {irq, rst_pulse}, 0);
    ticks(20);
    chk(!irq && !rst_pulse, "R1 idle", {irq, rst_pulse}, 0);

    wr(8'h02); kk();
    exp_pulse(4, "R9 enable without unlock");
    exp_pulse(4, "R3 repeat pulse");

    wr(8'h00); kk();
    exp_pulse(4, "R8 clear ignored");
    wr(8'h12); kk();
    exp_pulse(4, "R8 select ignored");

    wr(8'h06); wr(8'h12); kk();
    exp_pulse(8, "R7 select in window");
    wr(8'h06); repeat (3) cyc(); wr(8'h22); kk();
    exp_pulse(16, "R7 last window cycle");
    wr(8'h06); repeat (4) cyc(); wr(8'h32); kk();
    exp_pulse(16, "R8 window expired");
    wr(8'h06); wr(8'h00); kk(); ticks(40);
    chk(!irq && !rst_pulse, "R7 disable in window", {irq, rst_pulse}, 0);

    wr(8'h01); kk();
    exp_irq(4, "R2 first expiry");
    ticks(4);
    chk(irq && !rst_pulse, "R2 no reset", {irq, rst_pulse}, 2);
    ack();
    chk(!irq, "R11 ack clears", irq, 0);
    exp_irq(4, "R11 interrupt mode kept");
    ack();

    ticks(3); kk(); ticks(3);
    chk(!irq, "R5 kick restarts", irq, 0);
    ticks(1);
    chk(irq, "R5 full count", irq, 1);
    ack();

    wr(8'h03); kk();
    exp_irq(4, "R4 first interrupt");
    ack();
    chk(!irq, "R4 ack", irq, 0);
    exp_pulse(4, "R4 reset after ack");
    chk(!irq, "R4 ien dropped", irq, 0);
    wr(8'h03); kk();
    exp_irq(4, "R4 rearm");
    exp_pulse(4, "R4 pending then reset");
    ack();

    wr(8'h06); wr(8'h00);
    strap_on = 1'b1; kk();
    exp_pulse(4, "R10 strap forces");
    wr(8'h06); wr(8'h00); kk();
    exp_pulse(4, "R10 cannot disable");
    strap_on = 1'b0;

    for (int i = 0; i < 14; i++) begin
      int code, n;
      code = (i == 0) ? 12 : (i == 1) ? 15 : int'($urandom % 16);
      wr(8'h06); wr(8'((code << 4) | 1)); kk(); ack();
      n = 0;
      while (!irq && n < lim(code) + 2) begin
        bit t;
        t = ($urandom % 3) != 0;
        tick = t; cyc();
        if (t) n++;
      end
      tick = 1'b0;
      chk(irq && n == lim(code), "R6 select timeout", n, lim(code));
    end

    finish_run();
  end
endmodule